// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Hardware Table Walk

This block turns a 32-bit virtual address into a 30-bit physical address, using 4 KB pages. Each request goes first to a small, fully associative translation cache. All of its entries are compared in parallel against the virtual page number, which is bits 31..12 of the address. If an entry matches, the block returns the physical address on the cycle after it accepts the request. If no entry matches, the block reads one page-table entry from memory. That entry's address is the table base register plus the virtual page number. A valid entry is written into the translation cache and completes the request. An entry marked not-present completes the request with a fault flag.

Only one translation is in flight at a time. The block keeps a use bit for each cache entry. The bit is set when the entry is hit or filled, and one input clears all of them at once, so software can sample and reset them periodically to approximate least-recently-used. A flush input invalidates every cache entry in one cycle. Loading a new table base also flushes.

Top module: `addr_xlat_unit`

## Requirements
- R1: The physical address is the 18-bit physical page number placed above the untouched 12-bit page offset (vaddr bits 11..0).
- R2: A request whose page number matches a valid cache entry gives resp_valid=1, resp_fault=0 on the cycle after acceptance and issues no page-table read.
- R3: On a miss, pt_rd_en is high for exactly one cycle, with pt_rd_addr = table base + zero-extended page number.
- R4: A returned table entry has its present bit at bit 18 and its page number in bits 17..0. If the present bit is 1, the response carries the translated address and the entry is filled, so the next access to that page hits.
- R5: If the present bit is 0, the response has resp_fault=1 and nothing is filled, so a repeat access walks again.
- R6: A fill uses the lowest-numbered invalid entry. When all entries are valid, it uses a round-robin pointer that starts at entry 0 after reset and advances by one on each such fill.
- R7: flush invalidates all entries and clears all use bits in one cycle. A fill or use-bit set on the same edge is discarded.
- R8: ptr_load writes ptr_value into the table base register and also acts as a flush.
- R9: use_bits[i] is set when entry i is hit or filled, and use_clear clears every bit. On the same edge, a set wins over use_clear.
- R10: req_ready is high only while no walk is in progress; pt_rd_en never rises while req_ready is high; resp_fault is high only with resp_valid.
- R11: After reset, all entries are invalid, the use bits and the table base are zero, req_ready is 1, and resp_valid and pt_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 30 | Translated physical address |
| resp_fault | output | 1 | Page not present |
| ptr_load | input | 1 | Load table base (also flushes) |
| ptr_value | input | 32 | New table base |
| flush | input | 1 | Invalidate all cache entries |
| use_clear | input | 1 | Clear all use bits |
| use_bits | output | 8 | Per-entry use bits |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_rd_addr | output | 32 | Page-table entry address |
| pt_rd_valid | input | 1 | Read data valid |
| pt_rd_data | input | 19 | Entry: bit 18 present, bits 17..0 page number |

## Verification
The bench fills the cache from empty and then forces evictions. These runs expose a design that skips invalid entries or starts its rotation in the wrong place: it would evict a page that is still wanted, so a later access walks where a hit was expected. Faulting pages are accessed twice. A design that filled them would answer the second access from the cache, with no walk. A flush is raised on the very edge a walk completes. A design that let the fill through would show a use bit and hit afterwards. A use-clear is raised together with a hit, and a sweep over many page/offset pairs under a moved table base catches wrong address concatenation or a stale base.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int XL_VA_W  = 32;
  parameter int XL_OFF_W = 12;
  parameter int XL_PPN_W = 18;
  parameter int XL_PT_AW = 32;
  localparam int XL_VPN_W = XL_VA_W - XL_OFF_W;
  localparam int XL_PA_W  = XL_PPN_W + XL_OFF_W;
  localparam int XL_PTE_W = XL_PPN_W + 1;

  typedef enum logic [1:0] {WK_IDLE, WK_ISSUE, WK_WAIT} walk_state_e;

  function automatic logic [XL_VPN_W-1:0] vpn_of(input logic [XL_VA_W-1:0] va);
    return va[XL_VA_W-1:XL_OFF_W];
  endfunction

  function automatic logic [XL_OFF_W-1:0] off_of(input logic [XL_VA_W-1:0] va);
    return va[XL_OFF_W-1:0];
  endfunction

  function automatic logic [XL_PA_W-1:0] join_pa(input logic [XL_PPN_W-1:0] ppn,
                                                 input logic [XL_OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  function automatic logic [XL_PT_AW-1:0] pte_addr(input logic [XL_PT_AW-1:0] base,
                                                   input logic [XL_VPN_W-1:0] vpn);
    return base + XL_PT_AW'(vpn);
  endfunction

  function automatic logic pte_present(input logic [XL_PTE_W-1:0] pte);
    return pte[XL_PPN_W];
  endfunction

  function automatic logic [XL_PPN_W-1:0] pte_ppn(input logic [XL_PTE_W-1:0] pte);
    return pte[XL_PPN_W-1:0];
  endfunction
endpackage

// File: rtl/xlat_tlb_array.sv
module xlat_tlb_array #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PPN_W-1:0] look_ppn,
  output logic [N-1:0]     hit_vec,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     use_vec,
  input  logic             touch,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inval_all,
  input  logic             use_clr
);
  logic [PPN_W-1:0] ppn_all [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic             vld_e, use_e;
    logic [VPN_W-1:0] tag_e;
    logic [PPN_W-1:0] ppn_e;
    logic             fill_here, set_use;

    assign fill_here = fill_en && (fill_idx == IDX_W'(i));
    assign hit_vec[i] = vld_e && (tag_e == look_vpn);
    assign set_use = (touch && hit_vec[i]) || fill_here;

    always_ff @(posedge clk) begin
      if (!rst_n || inval_all) begin
        vld_e <= 1'b0;
        use_e <= 1'b0;
      end else begin
        if (fill_here) vld_e <= 1'b1;
        if (set_use)      use_e <= 1'b1;
        else if (use_clr) use_e <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_here && !inval_all) begin
        tag_e <= fill_vpn;
        ppn_e <= fill_ppn;
      end
    end

    assign valid_vec[i] = vld_e;
    assign use_vec[i]   = use_e;
    assign ppn_all[i]   = ppn_e;
  end

  always_comb begin
    look_hit = |hit_vec;
    look_ppn = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) look_ppn = ppn_all[i];
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             fill_en,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] rr_q, free_idx;
  logic             all_valid;

  assign all_valid = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign victim_idx = all_valid ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (fill_en && all_valid)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [XL_VPN_W-1:0] start_vpn,
  input  logic [XL_PT_AW-1:0] base,
  output logic                busy,
  output logic                pt_rd_en,
  output logic [XL_PT_AW-1:0] pt_rd_addr,
  input  logic                pt_rd_valid,
  input  logic [XL_PTE_W-1:0] pt_rd_data,
  output logic                done,
  output logic                done_ok,
  output logic [XL_PPN_W-1:0] done_ppn,
  output logic [XL_VPN_W-1:0] walk_vpn
);
  walk_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= WK_IDLE;
    else begin
      unique case (st_q)
        WK_IDLE:  if (start) st_q <= WK_ISSUE;
        WK_ISSUE: st_q <= WK_WAIT;
        WK_WAIT:  if (pt_rd_valid) st_q <= WK_IDLE;
        default:  st_q <= WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) walk_vpn <= '0;
    else if (start && st_q == WK_IDLE) walk_vpn <= start_vpn;
  end

  assign busy       = (st_q != WK_IDLE);
  assign pt_rd_en   = (st_q == WK_ISSUE);
  assign pt_rd_addr = pte_addr(base, walk_vpn);
  assign done       = (st_q == WK_WAIT) && pt_rd_valid;
  assign done_ok    = pte_present(pt_rd_data);
  assign done_ppn   = pte_ppn(pt_rd_data);
endmodule

// File: rtl/addr_xlat_unit.sv
module addr_xlat_unit
  import xlat_pkg::*;
#(
  parameter int TLB_ENTRIES = 8,
  localparam int IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [XL_VA_W-1:0]     req_vaddr,
  output logic                   req_ready,
  output logic                   resp_valid,
  output logic [XL_PA_W-1:0]     resp_paddr,
  output logic                   resp_fault,
  input  logic                   ptr_load,
  input  logic [XL_PT_AW-1:0]    ptr_value,
  input  logic                   flush,
  input  logic                   use_clear,
  output logic [TLB_ENTRIES-1:0] use_bits,
  output logic                   pt_rd_en,
  output logic [XL_PT_AW-1:0]    pt_rd_addr,
  input  logic                   pt_rd_valid,
  input  logic [XL_PTE_W-1:0]    pt_rd_data
);
  logic [XL_PT_AW-1:0]    base_q;
  logic [XL_OFF_W-1:0]    off_q;
  logic [TLB_ENTRIES-1:0] hit_vec, valid_vec;
  logic                   look_hit, busy, accept;
  logic [XL_PPN_W-1:0]    look_ppn, done_ppn;
  logic [XL_VPN_W-1:0]    walk_vpn;
  logic [IDX_W-1:0]       victim_idx;

  // Named events for the checker
  logic flush_evt, hit_evt, miss_evt, walk_done, walk_ok, fill_evt;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign flush_evt = flush || ptr_load;
  assign hit_evt   = accept && look_hit;
  assign miss_evt  = accept && !look_hit;
  assign fill_evt  = walk_done && walk_ok && !flush_evt;

  xlat_tlb_array #(.N(TLB_ENTRIES), .VPN_W(XL_VPN_W), .PPN_W(XL_PPN_W)) u_tlb (
    .clk, .rst_n,
    .look_vpn (vpn_of(req_vaddr)),
    .look_hit, .look_ppn, .hit_vec, .valid_vec,
    .use_vec  (use_bits),
    .touch    (hit_evt),
    .fill_en  (fill_evt),
    .fill_idx (victim_idx),
    .fill_vpn (walk_vpn),
    .fill_ppn (done_ppn),
    .inval_all(flush_evt),
    .use_clr  (use_clear)
  );

  xlat_victim #(.N(TLB_ENTRIES)) u_victim (
    .clk, .rst_n, .valid_vec, .fill_en(fill_evt), .victim_idx
  );

  xlat_walker u_walk (
    .clk, .rst_n,
    .start     (miss_evt),
    .start_vpn (vpn_of(req_vaddr)),
    .base      (base_q),
    .busy, .pt_rd_en, .pt_rd_addr, .pt_rd_valid, .pt_rd_data,
    .done      (walk_done),
    .done_ok   (walk_ok),
    .done_ppn, .walk_vpn
  );

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (ptr_load) base_q <= ptr_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= '0;
    else if (accept) off_q <= off_of(req_vaddr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= hit_evt || walk_done;
      resp_fault <= walk_done && !walk_ok;
      if (hit_evt)        resp_paddr <= join_pa(look_ppn, off_of(req_vaddr));
      else if (walk_done) resp_paddr <= walk_ok ? join_pa(done_ppn, off_q) : '0;
    end
  end
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_ready,
  input logic         pt_rd_en,
  input logic         resp_valid,
  input logic         resp_fault,
  input logic         flush,
  input logic         ptr_load,
  input logic [N-1:0] use_bits,
  input logic [N-1:0] hit_vec,
  input logic         hit_evt,
  input logic         walk_done,
  input logic         walk_ok
);
  a_r10_fault_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_valid);
  a_r10_busy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> !req_ready);
  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |=> !pt_rd_en);
  a_r2_hit_answers: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (resp_valid && !resp_fault && !pt_rd_en));
  a_r5_fault_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !walk_ok) |=> (resp_valid && resp_fault));
  a_r4_ok_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_ok) |=> (resp_valid && !resp_fault));
  a_r7_flush_clears_use: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (use_bits == '0));
  a_r8_load_clears_use: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (use_bits == '0));
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind addr_xlat_unit xlat_checker #(.N(TLB_ENTRIES)) u_xlat_chk (
  .clk, .rst_n, .req_ready, .pt_rd_en, .resp_valid, .resp_fault,
  .flush, .ptr_load, .use_bits, .hit_vec, .hit_evt, .walk_done, .walk_ok
);

// File: tb/tb_addr_xlat_unit.sv
module tb_addr_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        resp_valid;
  logic [29:0] resp_paddr;
  logic        resp_fault;
  logic        ptr_load = 1'b0;
  logic [31:0] ptr_value = '0;
  logic        flush = 1'b0;
  logic        use_clear = 1'b0;
  logic [7:0]  use_bits;
  logic        pt_rd_en;
  logic [31:0] pt_rd_addr;
  logic        pt_rd_valid = 1'b0;
  logic [18:0] pt_rd_data;

  int errors = 0, checks = 0, cycles = 0;
  int walk_cnt = 0, mem_cnt = 0;
  logic [31:0] mem_addr_q = '0, last_walk_addr = '0;
  logic [31:0] base;

  addr_xlat_unit dut (
    .clk, .rst_n, .req_valid, .req_vaddr, .req_ready, .resp_valid, .resp_paddr,
    .resp_fault, .ptr_load, .ptr_value, .flush, .use_clear, .use_bits,
    .pt_rd_en, .pt_rd_addr, .pt_rd_valid, .pt_rd_data
  );

  always #4 clk = ~clk;

  // Page-table memory: entry contents derived arithmetically from its address
  function automatic logic [18:0] pte_model(input logic [31:0] a);
    logic ok;
    logic [31:0] p;
    ok = (a % 5) != 0;
    p  = a * 37 + 11;
    return {ok, p[17:0]};
  endfunction

  assign pt_rd_data = pte_model(mem_addr_q);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    pt_rd_valid <= 1'b0;
    if (pt_rd_en) begin
      mem_addr_q     <= pt_rd_addr;
      last_walk_addr <= pt_rd_addr;
      walk_cnt       <= walk_cnt + 1;
      mem_cnt        <= 2;
    end else if (mem_cnt > 0) begin
      mem_cnt <= mem_cnt - 1;
      if (mem_cnt == 1) pt_rd_valid <= 1'b1;
    end
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [29:0] exp_pa(input logic [31:0] b, input logic [31:0] va);
    logic [18:0] e;
    e = pte_model(b + {12'd0, va[31:12]});
    return {e[17:0], va[11:0]};
  endfunction

  function automatic logic exp_fault(input logic [31:0] b, input logic [31:0] va);
    logic [18:0] e;
    e = pte_model(b + {12'd0, va[31:12]});
    return !e[18];
  endfunction

  task automatic xlate(input logic [31:0] va, input bit fl_done, input bit clr,
                       output logic flt, output logic [29:0] pa,
                       output int lat, output int walks);
    int w0;
    @(negedge clk);
    w0 = walk_cnt;
    if (!req_ready) chk("R10 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    use_clear = clr;
    lat = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      use_clear = 1'b0;
      flush = 1'b0;
      lat++;
      if (pt_rd_en && req_ready) chk("R10 ready during walk", 64'(req_ready), 64'd0);
      if (resp_valid) break;
      if (fl_done && pt_rd_valid) flush = 1'b1;
      if (lat > 60) begin
        chk("R10 response timeout", 64'(lat), 64'd0);
        break;
      end
    end
    flt = resp_fault;
    pa = resp_paddr;
    walks = walk_cnt - w0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk); ptr_load = 1'b1; ptr_value = b;
    @(negedge clk); ptr_load = 1'b0;
    base = b;
  endtask

  // Translate and check address/fault; expect a walk (1) or a hit (0)
  task automatic run(input string tag, input logic [31:0] va, input int exp_walk,
                     input bit fl_done, input bit clr);
    logic flt;
    logic [29:0] pa;
    int lat, walks;
    xlate(va, fl_done, clr, flt, pa, lat, walks);
    chk({tag, " R5 fault flag"}, 64'(flt), 64'(exp_fault(base, va)));
    if (!exp_fault(base, va)) chk({tag, " R1 R4 paddr"}, 64'(pa), 64'(exp_pa(base, va)));
    if (exp_walk >= 0) chk({tag, " R2 R3 walk count"}, 64'(walks), 64'(exp_walk));
    if (exp_walk == 0) chk({tag, " R2 hit latency"}, 64'(lat), 64'd1);
    if (exp_walk == 1)
      chk({tag, " R3 walk address"}, 64'(last_walk_addr), 64'(base + {12'd0, va[31:12]}));
  endtask

  initial begin
    logic [19:0] v [9];
    logic [19:0] fv;
    int n;
    base = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 req_ready", 64'(req_ready), 64'd1);
    chk("R11 resp_valid", 64'(resp_valid), 64'd0);
    chk("R11 pt_rd_en", 64'(pt_rd_en), 64'd0);
    chk("R11 use_bits", 64'(use_bits), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 use_bits after release", 64'(use_bits), 64'd0);
    // base 0 after reset: first walk address equals the page number
    run("R11 base zero", 32'h0000_3123, 1, 0, 0);
    load_base(32'h0000_1000);
    chk("R8 load clears use", 64'(use_bits), 64'd0);

    // pick nine present pages and one absent page under this base
    n = 0; fv = '0;
    for (int k = 64; k < 200 && (n < 9 || fv == 0); k++) begin
      if (!exp_fault(base, {20'(k), 12'h0})) begin
        if (n < 9) begin v[n] = 20'(k); n++; end
      end else if (fv == 0) fv = 20'(k);
    end

    // R6: fill from empty goes to entries 0..7 in order; R9 use bit set on fill
    for (int k = 0; k < 8; k++) begin
      run("R4 fill", {v[k], 12'(k * 341)}, 1, 0, 0);
      chk("R6 R9 fill index use bits", 64'(use_bits), 64'((1 << (k + 1)) - 1));
    end
    // R2: all now hit, new offsets
    for (int k = 0; k < 8; k++) run("R2 hit", {v[k], 12'(4095 - k * 97)}, 0, 0, 0);
    chk("R9 use all set", 64'(use_bits), 64'hFF);
    @(negedge clk); use_clear = 1'b1;
    @(negedge clk); use_clear = 1'b0;
    chk("R9 use_clear", 64'(use_bits), 64'd0);
    run("R9 clear with hit", {v[3], 12'h5A5}, 0, 0, 1);
    chk("R9 set wins over clear", 64'(use_bits), 64'h08);

    // R5: absent page faults and is not filled
    run("R5 fault first", {fv, 12'h010}, 1, 0, 0);
    run("R5 fault repeat", {fv, 12'h020}, 1, 0, 0);
    run("R5 entries kept", {v[0], 12'h001}, 0, 0, 0);

    // R6: round robin from entry 0 once full
    @(negedge clk); use_clear = 1'b1;
    @(negedge clk); use_clear = 1'b0;
    run("R6 evict entry0", {v[8], 12'hABC}, 1, 0, 0);
    chk("R6 rr entry0", 64'(use_bits), 64'h01);
    run("R6 evicted page walks", {v[0], 12'h111}, 1, 0, 0);
    chk("R6 rr entry1", 64'(use_bits), 64'h03);
    run("R6 untouched hits", {v[2], 12'h222}, 0, 0, 0);
    run("R6 second victim walks", {v[1], 12'h333}, 1, 0, 0);
    run("R6 entry3 still hits", {v[3], 12'h444}, 0, 0, 0);

    // R7: flush
    pulse_flush();
    chk("R7 flush clears use", 64'(use_bits), 64'd0);
    run("R7 walk after flush", {v[5], 12'h0F0}, 1, 0, 0);
    chk("R6 lowest invalid after flush", 64'(use_bits), 64'h01);
    run("R7 flush at fill", {v[6], 12'h0E0}, 1, 1, 0);
    chk("R7 fill discarded use", 64'(use_bits), 64'd0);
    run("R7 discarded fill walks", {v[6], 12'h0D0}, 1, 0, 0);

    // R8: new base flushes and redirects walks
    load_base(32'h0004_0000);
    chk("R8 use cleared", 64'(use_bits), 64'd0);
    run("R8 walk new base", {v[6], 12'h0C0}, 1, 0, 0);

    // sweep over a small page window with varied offsets
    for (int i = 0; i < 48; i++)
      run("R1 sweep", {20'(i % 12), 12'(i * 83)}, -1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule